// File: doc/BRIEF.md
# Serial-Loaded Configuration Register Port

This block sits on a CPU write bus and holds four 5-bit configuration registers that software loads one bit at a time. Any write to the upper half of the 64 KB address space (address bit 15 high) counts as a serial write. Bit 0 of the data byte is shifted into a hidden 5-bit shifter. When the fifth accepted bit arrives, the assembled value is committed to the register chosen by address bits 14:13, and the shifter starts over.

Two escape paths keep software and hardware in step. A write with data bit 7 set aborts any partial load. It also forces the two mode bits 3:2 of register 0 high. A write that lands fewer than two CPU cycles after the previous write is dropped, so the second half of a read-modify-write pair does not load a bit twice. CPU cycles are signalled by a one-clock `cycleTick` pulse. The block also reports which of the two pattern-bank registers (1 or 2) was committed most recently.

Top module: `cfg_serial_port`

## Requirements
- R1: Only a cycle with `busWe` high and `busAddr[15]` = 1 is a serial write. Any other bus activity leaves the shifter, the registers and the gap timing untouched.
- R2: Accepted bits fill the shifter LSB first. The first accepted `busData[0]` ends up in bit 0 of the committed value, and the fifth ends up in bit 4.
- R3: On the fifth accepted data write, the value is stored in register `busAddr[14:13]` (0 = `cfgMode`, 1 = `cfgPatA`, 2 = `cfgPatB`, 3 = `cfgBank`) and the shifter is cleared. A register changes only through such a commit, or through R5 for register 0.
- R4: An accepted write with `busData[7]` = 1 empties the shifter and its bit count, and its `busData[0]` is discarded. The next five data writes form a fresh value.
- R5: An accepted write with `busData[7]` = 1 sets `cfgMode[3:2]` to 2'b11 and leaves `cfgMode[4]`, `cfgMode[1:0]` and the other three registers unchanged.
- R6: A serial write is ignored when fewer than 2 `cycleTick` pulses have occurred since the previous serial write. The ignored write still restarts the gap timing. A tick in the same clock as a write is counted before that write.
- R7: The first serial write after reset is accepted, whatever the tick count.
- R8: During reset, `cfgMode` = 0x0C, `cfgPatA` = `cfgPatB` = 0, `cfgBank` = 0x10 if `variantSel` is 1 and 0x00 otherwise, and `lastPatB` = 0.
- R9: `lastPatB` becomes 1 after a commit to register 2 and 0 after a commit to register 1. Commits to registers 0 and 3 leave it unchanged.
- R10: Register and flag outputs take their new value at the clock edge that samples the committing (or bit-7) write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busWe | input | 1 | Bus write strobe, one clock per CPU write |
| busAddr | input | 16 | Bus write address |
| busData | input | 8 | Bus write data |
| cycleTick | input | 1 | One-clock pulse per CPU cycle |
| variantSel | input | 1 | Selects the reset value of `cfgBank[4]` |
| cfgMode | output | 5 | Register 0 |
| cfgPatA | output | 5 | Register 1 |
| cfgPatB | output | 5 | Register 2 |
| cfgBank | output | 5 | Register 3 |
| lastPatB | output | 1 | 1 when register 2 was the last pattern register committed |

## Verification
Every result of this block is due one clock after the bus cycle that causes it. A committing write or a bit-7 write shows on the register outputs at the next rising edge. An ignored write must leave them unchanged at that same edge. The bench drives each bus cycle at a falling edge and updates its reference model after the rising edge that samples it. It compares every output at the following falling edge, so each check falls on the cycle a result is due, and a change one cycle late or early is caught. The gap rule is exercised with explicit tick counts of 0, 1 and 2, including a tick in the same clock as the write.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;

  localparam int VAL_W    = 5;
  localparam int NUM_REGS = 4;
  localparam int IDX_W    = $clog2(NUM_REGS);

  // Register 0 bits forced high by a bit-7 write
  localparam logic [VAL_W-1:0] FORCE_MASK = 5'b01100;

  // Register indices with a role in the last-pattern flag
  localparam logic [IDX_W-1:0] IDX_PAT_A = 2'd1;
  localparam logic [IDX_W-1:0] IDX_PAT_B = 2'd2;

  typedef struct packed {
    logic             shiftEn;    // shift the current data bit in
    logic             clearBuf;   // empty the shifter
    logic             forceMode;  // set the forced bits of register 0
    logic             commit;     // store the assembled value
    logic [IDX_W-1:0] idx;        // target register of a commit
  } strobe_t;

  function automatic logic [VAL_W-1:0] resetValue(int idx, logic variant);
    logic [VAL_W-1:0] v;
    v = '0;
    if (idx == 0) v = FORCE_MASK;
    if (idx == NUM_REGS-1) v[VAL_W-1] = variant;
    return v;
  endfunction

endpackage

// File: rtl/cfg_serial_ctrl.sv
module cfg_serial_ctrl
  import cfg_serial_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int MIN_GAP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              dataReset,
  input  logic              cycleTick,
  output strobe_t           str
);

  localparam int AGE_W = $clog2(MIN_GAP + 1);
  localparam int CNT_W = $clog2(VAL_W + 1);
  localparam logic [AGE_W-1:0] AGE_MAX  = AGE_W'(MIN_GAP);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(VAL_W - 1);

  logic [AGE_W-1:0] age;
  logic [AGE_W-1:0] ageNow;
  logic [CNT_W-1:0] bitCount;
  logic             hit;
  logic             accept;
  logic             lastBit;

  // Ticks since the previous serial write, saturating at the required gap;
  // a tick in the write's own clock is counted first.
  always_comb begin
    ageNow = age;
    if (cycleTick && (age < AGE_MAX)) ageNow = age + 1'b1;
  end

  assign hit     = busWe && busAddr[ADDR_W-1];
  assign accept  = hit && (ageNow >= AGE_MAX);
  assign lastBit = (bitCount == CNT_LAST);

  always_comb begin
    str.forceMode = accept && dataReset;
    str.shiftEn   = accept && !dataReset;
    str.commit    = accept && !dataReset && lastBit;
    str.clearBuf  = accept && (dataReset || lastBit);
    str.idx       = busAddr[ADDR_W-2 -: IDX_W];
  end

  // Reset to a saturated age so the first write is accepted
  always_ff @(posedge clk) begin
    if (!rstN)    age <= AGE_MAX;
    else if (hit) age <= '0;
    else          age <= ageNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            bitCount <= '0;
    else if (str.clearBuf) bitCount <= '0;
    else if (str.shiftEn)  bitCount <= bitCount + 1'b1;
  end

  assert_count_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    bitCount <= CNT_LAST);

  assert_gap_block_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hit && (ageNow < AGE_MAX)) |=> $stable(bitCount));

  assert_window_only_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!hit) |=> $stable(bitCount));

  assert_first_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rstN) ##0 hit) |-> accept);

endmodule

// File: rtl/cfg_serial_dp.sv
module cfg_serial_dp
  import cfg_serial_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           variantSel,
  input  logic                           bitIn,
  input  strobe_t                        str,
  output logic [NUM_REGS-1:0][VAL_W-1:0] cfgReg,
  output logic                           lastPatB
);

  logic [VAL_W-1:0] shiftBuf;
  logic [VAL_W-1:0] shiftNext;

  assign shiftNext = {bitIn, shiftBuf[VAL_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rstN)             shiftBuf <= '0;
    else if (str.clearBuf) shiftBuf <= '0;
    else if (str.shiftEn)  shiftBuf <= shiftNext;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gen_reg
    always_ff @(posedge clk) begin
      if (!rstN)
        cfgReg[g] <= resetValue(g, variantSel);
      else if (str.commit && (str.idx == IDX_W'(g)))
        cfgReg[g] <= shiftNext;
      else if ((g == 0) && str.forceMode)
        cfgReg[g] <= cfgReg[g] | FORCE_MASK;
    end

    if (g != 0) begin : gen_hold_chk
      assert_reg_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
        !$stable(cfgReg[g]) |-> $past(str.commit && (str.idx == IDX_W'(g))));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) lastPatB <= 1'b0;
    else if (str.commit && (str.idx == IDX_PAT_A)) lastPatB <= 1'b0;
    else if (str.commit && (str.idx == IDX_PAT_B)) lastPatB <= 1'b1;
  end

  assert_force_bits_R5: assert property (@(posedge clk) disable iff (!rstN)
    str.forceMode |=> (cfgReg[0][3:2] == 2'b11) && $stable(cfgReg[0][4])
                      && $stable(cfgReg[0][1:0]));

  assert_clear_after_commit_R3: assert property (@(posedge clk) disable iff (!rstN)
    str.commit |=> (shiftBuf == '0));

  assert_reset_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    str.forceMode |=> (shiftBuf == '0));

  assert_last_pat_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lastPatB) |-> $past(str.commit && ((str.idx == IDX_PAT_A) || (str.idx == IDX_PAT_B))));

endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_serial_pkg::*;
#(
  parameter int MIN_GAP = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWe,
  input  logic [15:0] busAddr,
  input  logic [7:0]  busData,
  input  logic        cycleTick,
  input  logic        variantSel,
  output logic [4:0]  cfgMode,
  output logic [4:0]  cfgPatA,
  output logic [4:0]  cfgPatB,
  output logic [4:0]  cfgBank,
  output logic        lastPatB
);

  strobe_t                        str;
  logic [NUM_REGS-1:0][VAL_W-1:0] cfgReg;

  cfg_serial_ctrl #(.ADDR_W(16), .MIN_GAP(MIN_GAP)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWe     (busWe),
    .busAddr   (busAddr),
    .dataReset (busData[7]),
    .cycleTick (cycleTick),
    .str       (str)
  );

  cfg_serial_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .variantSel (variantSel),
    .bitIn      (busData[0]),
    .str        (str),
    .cfgReg     (cfgReg),
    .lastPatB   (lastPatB)
  );

  assign cfgMode = cfgReg[0];
  assign cfgPatA = cfgReg[1];
  assign cfgPatB = cfgReg[2];
  assign cfgBank = cfgReg[3];

endmodule

// File: tb/cfg_serial_port_bench.sv
`timescale 1ns/1ps
module cfg_serial_port_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busData = '0;
  logic        cycleTick = 1'b0;
  logic        variantSel = 1'b1;
  logic [4:0]  cfgMode, cfgPatA, cfgPatB, cfgBank;
  logic        lastPatB;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [4:0] mReg [4];
  logic [4:0] mShift;
  int         mCnt;
  int         mAge;
  logic       mLast;

  always #2.5 clk = ~clk;

  cfg_serial_port u_cfg_serial_port (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busData(busData),
    .cycleTick(cycleTick), .variantSel(variantSel), .cfgMode(cfgMode),
    .cfgPatA(cfgPatA), .cfgPatB(cfgPatB), .cfgBank(cfgBank), .lastPatB(lastPatB)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    check({req, " mode"}, {3'b0, cfgMode}, {3'b0, mReg[0]});
    check({req, " patA"}, {3'b0, cfgPatA}, {3'b0, mReg[1]});
    check({req, " patB"}, {3'b0, cfgPatB}, {3'b0, mReg[2]});
    check({req, " bank"}, {3'b0, cfgBank}, {3'b0, mReg[3]});
    check({req, " last"}, {7'b0, lastPatB}, {7'b0, mLast});
  endtask

  task automatic modelReset(logic variant);
    mReg[0] = 5'h0C; mReg[1] = '0; mReg[2] = '0;
    mReg[3] = variant ? 5'h10 : 5'h00;
    mShift = '0; mCnt = 0; mAge = 2; mLast = 1'b0;
  endtask

  task automatic modelStep(logic we, logic [15:0] addr, logic [7:0] data, logic tick);
    int ageNow;
    ageNow = (tick && mAge < 2) ? mAge + 1 : mAge;
    if (we && addr[15]) begin
      if (ageNow >= 2) begin
        if (data[7]) begin
          mShift = '0; mCnt = 0; mReg[0] = mReg[0] | 5'h0C;
        end else begin
          mShift = {data[0], mShift[4:1]};
          mCnt++;
          if (mCnt == 5) begin
            mReg[addr[14:13]] = mShift;
            if (addr[14:13] == 2'd1) mLast = 1'b0;
            if (addr[14:13] == 2'd2) mLast = 1'b1;
            mShift = '0; mCnt = 0;
          end
        end
      end
      mAge = 0;
    end else begin
      mAge = ageNow;
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(logic we, logic [15:0] addr, logic [7:0] data, logic tick);
    busWe = we; busAddr = addr; busData = data; cycleTick = tick;
    @(posedge clk);
    modelStep(we, addr, data, tick);
    @(negedge clk);
    busWe = 1'b0; cycleTick = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(1'b0, 16'h0000, 8'h00, 1'b1);
  endtask

  task automatic wr(logic [15:0] addr, logic [7:0] data, int gap);
    ticks(gap);
    step(1'b1, addr, data, 1'b0);
  endtask

  task automatic wr5(logic [15:0] addr, logic [4:0] val, int firstGap);
    for (int i = 0; i < 5; i++) wr(addr, {7'b0, val[i]}, (i == 0) ? firstGap : 2);
  endtask

  task automatic doReset(logic variant);
    @(negedge clk);
    rstN = 1'b0; variantSel = variant; busWe = 1'b0; cycleTick = 1'b0;
    repeat (3) @(negedge clk);
    modelReset(variant);
    rstN = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    modelReset(1'b1);
    repeat (3) @(negedge clk);
    // R8: reset values with variant set
    check("R8 mode", {3'b0, cfgMode}, 8'h0C);
    check("R8 patA", {3'b0, cfgPatA}, 8'h00);
    check("R8 patB", {3'b0, cfgPatB}, 8'h00);
    check("R8 bank", {3'b0, cfgBank}, 8'h10);
    check("R8 last", {7'b0, lastPatB}, 8'h00);
    rstN = 1'b1;

    // R7: first write right after reset with no ticks; R2 bit order
    wr5(16'hA000, 5'h0D, 0);
    check("R7/R2 patA", {3'b0, cfgPatA}, 8'h0D);
    check("R9 last after patA", {7'b0, lastPatB}, 8'h00);

    // R3, R9: commit to reg 2 then reg 3
    wr5(16'hC000, 5'h16, 2);
    check("R3 patB", {3'b0, cfgPatB}, 8'h16);
    check("R9 last after patB", {7'b0, lastPatB}, 8'h01);
    wr(16'hE000, 8'h01, 2); wr(16'hE000, 8'h01, 2);
    wr(16'hE000, 8'h00, 2); wr(16'hE000, 8'h00, 2);
    check("R10 bank before fifth", {3'b0, cfgBank}, 8'h10);
    wr(16'hE000, 8'h00, 2);
    check("R10 bank after fifth", {3'b0, cfgBank}, 8'h03);
    check("R9 last after bank", {7'b0, lastPatB}, 8'h01);

    // R1: writes below 0x8000 and strobe-less cycles are invisible
    wr(16'hA000, 8'h01, 2); wr(16'hA000, 8'h01, 2);
    wr(16'h6000, 8'h01, 2); wr(16'h7FFF, 8'h00, 0);
    step(1'b0, 16'hA000, 8'h01, 1'b0);
    wr(16'hA000, 8'h00, 0);   // gap counted from previous window write: 2 ticks earlier
    wr(16'hA000, 8'h00, 2); wr(16'hA000, 8'h00, 2);
    check("R1 patA", {3'b0, cfgPatA}, 8'h03);

    // R4: partial load aborted by bit-7 write
    wr(16'hA000, 8'h01, 2); wr(16'hA000, 8'h01, 2); wr(16'hA000, 8'h01, 2);
    wr(16'h8000, 8'h81, 2);
    wr5(16'hA000, 5'h0A, 2);
    check("R4 patA", {3'b0, cfgPatA}, 8'h0A);

    // R5: forced bits of register 0
    wr5(16'h8000, 5'h11, 2);
    check("R3 mode", {3'b0, cfgMode}, 8'h11);
    wr(16'hE000, 8'hFF, 2);
    check("R5 mode", {3'b0, cfgMode}, 8'h1D);
    check("R5 bank", {3'b0, cfgBank}, 8'h03);
    check("R5 patB", {3'b0, cfgPatB}, 8'h16);

    // R6: suppression, restart on ignored write, tick in write clock
    wr(16'hC000, 8'h01, 2);
    wr(16'hC000, 8'h01, 1);   // ignored
    wr(16'hC000, 8'h01, 1);   // ignored: one tick after the ignored one
    wr(16'hC000, 8'h00, 2);
    wr(16'hC000, 8'h00, 2);
    wr(16'hC000, 8'h00, 2);
    ticks(1);
    step(1'b1, 16'hC000, 8'h01, 1'b1);  // second tick in its own clock: accepted
    check("R6 patB", {3'b0, cfgPatB}, 8'h11);
    check("R6 all", {3'b0, cfgPatA}, 8'h0A);

    // R8: reset with variant clear
    doReset(1'b0);
    check("R8 bank v0", {3'b0, cfgBank}, 8'h00);
    check("R8 mode v0", {3'b0, cfgMode}, 8'h0C);
    check("R8 last v0", {7'b0, lastPatB}, 8'h00);

    // random mix checked against the model (R1..R6, R9)
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [15:0] a;
      logic [7:0]  d;
      r = $urandom % 8;
      if (r < 3) begin
        step(1'b0, 16'($urandom), 8'($urandom), 1'b1);
      end else begin
        a = 16'($urandom);
        a[15] = ($urandom % 8) != 0;
        d = 8'($urandom);
        d[7] = ($urandom % 12) == 0;
        step(1'b1, a, d, 1'($urandom % 2));
      end
      checkAll("R3 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule